// File: doc/BRIEF.md
# Two-Word Accumulator Processor Core

This block is a small 12-bit processor with one address per instruction. It keeps all of its code and data in a single shared memory of 4096 words. Every instruction takes two consecutive words. The first word is an opcode. The second word is either an immediate value or a memory address. The only state a program can see is the accumulator and the program counter. The opcode register, the operand register and the memory address register are internal.

A small microprogram ROM steps through four operation classes: store, jump, ALU with an immediate operand, and ALU with a memory operand. A load is an ALU operation that passes the operand through unchanged. Most datapath controls come straight from opcode fields.

Input and output reuse existing instructions:
- Reading a device is an ALU instruction that takes its operand from the input port.
- Writing a device is a store that goes to the output port instead of memory.
- Polling a device is a conditional jump on its ready flag.

There is no index register. Table walks and subroutine returns work by storing into the program's own address words. The memory sits outside the block, as a synchronous RAM with a read latency of one cycle.

Top module: `wp_core`

## Requirements
- R1: While reset is held, the core shows a program counter of 0, an accumulator of 0 and a low halt flag. It drives a read of address 0.
- R2: The core fetches the opcode word at PC and then the operand word at PC+1. By the time the class is dispatched, PC has advanced by exactly 2. When a store or jump condition is false, the next instruction is fetched from the original PC+2.
- R3: The opcode fields are as follows:
  - Bits [11:10] hold the class: 0 = store, 1 = jump, 2 = ALU immediate, 3 = ALU memory.
  - Bits [9:6] hold the ALU function, with acc as operand A and the operand as B: 0 = pass B, 1 = A+B, 2 = A-B, 3 = AND, 4 = OR, 5 = XOR, 6 = NOT A, 7 = A+1. All results wrap modulo 4096. Codes 8 to 15 keep A.
- R4: In ALU memory class (3), operand B is the word read from memory at the address held in the second word.
- R5: The store class (0) writes the accumulator into memory at the address held in the second word when its condition holds.
- R6: Bits [5:3] hold the condition code: 0 = always, 1 = acc is zero, 2 = acc bit 11 is set, 3 = acc is nonzero, 4 = device ready. Codes 5 to 7 are never true. A store whose condition is false leaves memory unchanged.
- R7: When its condition holds, the jump class (1) loads PC with the second word.
- R8: Bit 2 is the I/O flag. In an ALU class with bit 2 set, operand B is the input port value, and the input-take strobe pulses for one cycle.
- R9: A store with bit 2 set and its condition true pulses the output-valid strobe, with the accumulator on the output data port. It does not write memory.
- R10: Words written by stores are seen by later fetches, so a program can rewrite an operand address or a return address and execute it.
- R11: A jump-class opcode with bit 0 set halts the core. After that, the halt flag stays high, PC holds, and no memory access is made. PC then equals the halt address plus 2.
- R12: The accumulator changes only on the execute step of an ALU-class instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read request; data is returned on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 12 | Write data (the accumulator) |
| mem_rdata | input | 12 | Read data, valid one cycle after mem_rd |
| io_in_data | input | 12 | Input device word |
| io_in_take | output | 1 | Pulses when the input word is consumed |
| io_out_data | output | 12 | Output device word |
| io_out_valid | output | 1 | Pulses when io_out_data is to be taken |
| io_ready | input | 1 | Device ready flag, used by condition code 4 |
| halted | output | 1 | High once a halt opcode has been executed |
| acc | output | 12 | Accumulator |
| pc | output | 12 | Program counter |

## Verification
The case that is hardest to reach from the ports is a fetch that returns a word the program itself wrote moments earlier. This has to hold both for an operand address that is advanced on every pass of a loop and for one that is planted before the instruction that uses it. The stimulus gets there with a table-summing loop. The loop loads its own operand word, increments it, stores it back and repeats until the address reaches the end of the table. The final sum and the rewritten word then show that each pass read the fresh value.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int UAW = 4;

  typedef enum logic [UAW-1:0] {
    U_FOP   = 4'd0,
    U_FARG  = 4'd1,
    U_DISP  = 4'd2,
    U_STORE = 4'd3,
    U_JUMP  = 4'd4,
    U_MREAD = 4'd5,
    U_MLOAD = 4'd6,
    U_HALT  = 4'd7,
    U_EXEC  = 4'd8
  } uaddr_t;

  typedef enum logic [1:0] {
    CLS_STORE = 2'd0,
    CLS_JUMP  = 2'd1,
    CLS_AIMM  = 2'd2,
    CLS_AMEM  = 2'd3
  } cls_t;

  localparam logic [3:0] FN_PASS = 4'd0;
  localparam logic [3:0] FN_ADD  = 4'd1;
  localparam logic [3:0] FN_SUB  = 4'd2;
  localparam logic [3:0] FN_AND  = 4'd3;
  localparam logic [3:0] FN_OR   = 4'd4;
  localparam logic [3:0] FN_XOR  = 4'd5;
  localparam logic [3:0] FN_NOT  = 4'd6;
  localparam logic [3:0] FN_INC  = 4'd7;

  localparam logic [2:0] CC_ALW = 3'd0;
  localparam logic [2:0] CC_ZER = 3'd1;
  localparam logic [2:0] CC_NEG = 3'd2;
  localparam logic [2:0] CC_NZ  = 3'd3;
  localparam logic [2:0] CC_RDY = 3'd4;

  // one microprogram word: 14 bits
  typedef struct packed {
    logic   asel_mar;
    logic   rd;
    logic   wr;
    logic   pc_inc;
    logic   pc_ld;
    logic   ld_op;
    logic   ld_arg;
    logic   ld_mar;
    logic   ld_acc;
    logic   disp;
    uaddr_t nxt;
  } uword_t;
endpackage

// File: rtl/wp_alu.sv
module wp_alu #(
  parameter int DW = 12
) (
  input  logic [3:0]    fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  import wp_pkg::*;

  always_comb begin
    unique case (fn)
      FN_PASS: y = b;
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      FN_NOT:  y = ~a;
      FN_INC:  y = a + {{(DW-1){1'b0}}, 1'b1};
      default: y = a;
    endcase
  end
endmodule

// File: rtl/wp_cond.sv
module wp_cond #(
  parameter int DW = 12
) (
  input  logic [2:0]    cc,
  input  logic [DW-1:0] acc,
  input  logic          ready,
  output logic          ok
);
  import wp_pkg::*;

  logic is_zero;
  assign is_zero = (acc == '0);

  always_comb begin
    unique case (cc)
      CC_ALW:  ok = 1'b1;
      CC_ZER:  ok = is_zero;
      CC_NEG:  ok = acc[DW-1];
      CC_NZ:   ok = !is_zero;
      CC_RDY:  ok = ready;
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/wp_urom.sv
module wp_urom (
  input  wp_pkg::uaddr_t ua,
  output wp_pkg::uword_t uw
);
  import wp_pkg::*;

  always_comb begin
    uw = '0;
    uw.nxt = U_FOP;
    unique case (ua)
      U_FOP: begin
        uw.rd = 1'b1; uw.pc_inc = 1'b1; uw.nxt = U_FARG;
      end
      U_FARG: begin
        uw.ld_op = 1'b1; uw.rd = 1'b1; uw.pc_inc = 1'b1; uw.nxt = U_DISP;
      end
      U_DISP: begin
        uw.ld_arg = 1'b1; uw.ld_mar = 1'b1; uw.disp = 1'b1;
      end
      U_STORE: begin
        uw.asel_mar = 1'b1; uw.wr = 1'b1;
      end
      U_JUMP: begin
        uw.pc_ld = 1'b1;
      end
      U_MREAD: begin
        uw.asel_mar = 1'b1; uw.rd = 1'b1; uw.nxt = U_MLOAD;
      end
      U_MLOAD: begin
        uw.ld_arg = 1'b1; uw.nxt = U_EXEC;
      end
      U_EXEC: begin
        uw.ld_acc = 1'b1;
      end
      U_HALT: begin
        uw.nxt = U_HALT;
      end
      default: uw.nxt = U_FOP;
    endcase
  end
endmodule

// File: rtl/wp_seq.sv
module wp_seq (
  input  logic           clk,
  input  logic           rst_ni,
  input  wp_pkg::uword_t uw,
  input  wp_pkg::cls_t   cls,
  input  logic           halt_bit,
  output wp_pkg::uaddr_t ua
);
  import wp_pkg::*;

  uaddr_t ua_q, ua_d, disp_tgt;

  always_comb begin
    unique case (cls)
      CLS_STORE: disp_tgt = U_STORE;
      CLS_JUMP:  disp_tgt = halt_bit ? U_HALT : U_JUMP;
      CLS_AIMM:  disp_tgt = U_EXEC;
      default:   disp_tgt = U_MREAD;
    endcase
    ua_d = uw.disp ? disp_tgt : uw.nxt;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ua_q <= U_FOP;
    else         ua_q <= ua_d;
  end

  assign ua = ua_q;

  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ua_q == U_FOP) |=> (ua_q == U_FARG));

  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ua_q == U_HALT) |=> (ua_q == U_HALT));
endmodule

// File: rtl/wp_core.sv
module wp_core #(
  parameter int DW = 12,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] io_in_data,
  output logic          io_in_take,
  output logic [DW-1:0] io_out_data,
  output logic          io_out_valid,
  input  logic          io_ready,
  output logic          halted,
  output logic [DW-1:0] acc,
  output logic [AW-1:0] pc
);
  import wp_pkg::*;

  localparam int CLS_HI = DW - 1;
  localparam int FN_HI  = DW - 3;
  localparam int CC_HI  = DW - 7;
  localparam int IO_BIT = 2;
  localparam int HL_BIT = 0;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  logic [DW-1:0] op_q, op_d, arg_q, arg_d, acc_q, acc_d, alu_y, b_opnd;
  logic [AW-1:0] pc_q, pc_d, mar_q, mar_d;
  logic          cond_ok, io_f;
  logic          unused_bit;
  uaddr_t        ua;
  uword_t        uw;
  cls_t          cls;

  assign cls        = cls_t'(op_q[CLS_HI -: 2]);
  assign io_f       = op_q[IO_BIT];
  assign unused_bit = op_q[1];

  wp_urom u_urom (.ua(ua), .uw(uw));

  wp_seq u_seq (
    .clk(clk), .rst_ni(rst_i), .uw(uw), .cls(cls),
    .halt_bit(op_q[HL_BIT]), .ua(ua)
  );

  wp_cond #(.DW(DW)) u_cond (
    .cc(op_q[CC_HI -: 3]), .acc(acc_q), .ready(io_ready), .ok(cond_ok)
  );

  assign b_opnd = io_f ? io_in_data : arg_q;

  wp_alu #(.DW(DW)) u_alu (
    .fn(op_q[FN_HI -: 4]), .a(acc_q), .b(b_opnd), .y(alu_y)
  );

  // next-state logic
  always_comb begin
    op_d  = op_q;
    arg_d = arg_q;
    mar_d = mar_q;
    acc_d = acc_q;
    pc_d  = pc_q;
    if (uw.ld_op)  op_d  = mem_rdata;
    if (uw.ld_arg) arg_d = mem_rdata;
    if (uw.ld_mar) mar_d = mem_rdata[AW-1:0];
    if (uw.ld_acc) acc_d = alu_y;
    if (uw.pc_ld && cond_ok) pc_d = arg_q[AW-1:0];
    else if (uw.pc_inc)      pc_d = pc_q + {{(AW-1){1'b0}}, 1'b1};
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      op_q  <= '0;
      arg_q <= '0;
      mar_q <= '0;
      acc_q <= '0;
      pc_q  <= '0;
    end else begin
      op_q  <= op_d;
      arg_q <= arg_d;
      mar_q <= mar_d;
      acc_q <= acc_d;
      pc_q  <= pc_d;
    end
  end

  assign mem_addr     = uw.asel_mar ? mar_q : pc_q;
  assign mem_rd       = uw.rd;
  assign mem_wr       = uw.wr && cond_ok && !io_f;
  assign mem_wdata    = acc_q;
  assign io_out_valid = uw.wr && cond_ok && io_f;
  assign io_out_data  = acc_q;
  assign io_in_take   = uw.ld_acc && io_f;
  assign halted       = (ua == U_HALT);
  assign acc          = acc_q;
  assign pc           = pc_q;

  // R2
  pc_two_step_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (ua == U_DISP) |-> (pc_q == $past(pc_q, 2) + {{(AW-2){1'b0}}, 2'd2}));

  // R12
  acc_exec_only_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(acc_q) |-> $past(ua == U_EXEC));

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i)
    halted |=> (halted && !mem_rd && !mem_wr && $stable(pc_q)));

  // R9
  io_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_i)
    io_out_valid |-> !mem_wr);
endmodule

// File: tb/wp_core_bench.sv
module wp_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr, mem_wdata, mem_rdata, io_in_data, io_out_data, acc, pc;
  logic        mem_rd, mem_wr, io_in_take, io_out_valid, io_ready, halted;

  always #4 clk = ~clk;

  wp_core u_wp_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_in_data(io_in_data), .io_in_take(io_in_take),
    .io_out_data(io_out_data), .io_out_valid(io_out_valid),
    .io_ready(io_ready), .halted(halted), .acc(acc), .pc(pc)
  );

  int errors = 0;
  int checks = 0;

  // bench memory, loader port and strobe counters
  logic [11:0] mem [0:4095];
  logic        ld_clr = 1'b0, ld_we = 1'b0, cnt_clr = 1'b0;
  logic [11:0] ld_addr = '0, ld_data = '0;
  int          in_cnt, out_cnt;
  logic [11:0] out_last;

  always @(posedge clk) begin
    if (ld_clr) begin
      for (int i = 0; i < 4096; i++) mem[i] <= '0;
    end else if (ld_we) mem[ld_addr] <= ld_data;
    else if (mem_wr)    mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (cnt_clr) begin
      in_cnt <= 0; out_cnt <= 0; out_last <= '0;
    end else begin
      if (io_in_take) in_cnt <= in_cnt + 1;
      if (io_out_valid) begin
        out_cnt  <= out_cnt + 1;
        out_last <= io_out_data;
      end
    end
  end

  localparam int ST = 0, JP = 1, AI = 2, AM = 3;

  function automatic logic [11:0] op(int cls, int fn, int cc, int io, int hl);
    return {cls[1:0], fn[3:0], cc[2:0], io[0], 1'b0, hl[0]};
  endfunction

  function automatic logic [11:0] alu_ref(int fn, logic [11:0] a, logic [11:0] b);
    case (fn)
      0: return b;
      1: return a + b;
      2: return a - b;
      3: return a & b;
      4: return a | b;
      5: return a ^ b;
      6: return ~a;
      7: return a + 12'd1;
      default: return a;
    endcase
  endfunction

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(int a, logic [11:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a[11:0]; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic ins(int a, logic [11:0] o, logic [11:0] w);
    put(a, o);
    put(a + 1, w);
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_n = 1'b0; cnt_clr = 1'b1; ld_clr = 1'b1;
    @(negedge clk);
    ld_clr = 1'b0;
  endtask

  task automatic run_prog(string tag);
    int n;
    @(negedge clk);
    cnt_clr = 1'b0;
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (!halted) begin
      errors++;
      $display("FAIL %s: actual=running expected=halted", tag);
    end
  endtask

  task automatic t_reset();
    begin_prog();
    ins(0, op(AI, 0, 0, 0, 0), 12'h5A5);
    ins(2, op(JP, 0, 0, 0, 1), 12'h000);
    run_prog("R11 reset prep");
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pc in reset", pc, 12'h000);
    chk("R1 acc in reset", acc, 12'h000);
    chk("R1 halted in reset", {11'd0, halted}, 12'h000);
    chk("R1 read request", {11'd0, mem_rd}, 12'h001);
    chk("R1 read address", mem_addr, 12'h000);
  endtask

  task automatic t_alu_imm(logic [11:0] a, logic [11:0] b);
    for (int fn = 0; fn < 9; fn++) begin
      begin_prog();
      ins(0, op(AI, 0, 0, 0, 0), a);
      ins(2, op(AI, fn, 0, 0, 0), b);
      ins(4, op(JP, 0, 0, 0, 1), 12'h000);
      run_prog("R3 run");
      chk($sformatf("R3 fn %0d", fn), acc, alu_ref(fn, a, b));
      chk("R2 pc at halt", pc, 12'h006);
    end
  endtask

  task automatic t_alu_mem();
    begin_prog();
    put(12'h100, 12'h123);
    put(12'h101, 12'h0F0);
    ins(0, op(AM, 0, 0, 0, 0), 12'h100);
    ins(2, op(AM, 1, 0, 0, 0), 12'h101);
    ins(4, op(ST, 0, 0, 0, 0), 12'h102);
    ins(6, op(JP, 0, 0, 0, 1), 12'h000);
    run_prog("R4 run");
    chk("R4 load+add from memory", acc, 12'h213);
    chk("R5 stored word", mem[12'h102], 12'h213);
  endtask

  task automatic t_cond_store();
    begin_prog();
    put(12'h200, 12'h555);
    put(12'h201, 12'hAAA);
    put(12'h202, 12'h999);
    put(12'h203, 12'h777);
    ins(0, op(AI, 0, 0, 0, 0), 12'h000);
    ins(2, op(ST, 0, 1, 0, 0), 12'h200);
    ins(4, op(AI, 0, 0, 0, 0), 12'h001);
    ins(6, op(ST, 0, 1, 0, 0), 12'h201);
    ins(8, op(ST, 0, 3, 0, 0), 12'h202);
    ins(10, op(ST, 0, 5, 0, 0), 12'h203);
    ins(12, op(JP, 0, 0, 0, 1), 12'h000);
    run_prog("R6 run");
    chk("R5 store if zero taken", mem[12'h200], 12'h000);
    chk("R6 store if zero skipped", mem[12'h201], 12'hAAA);
    chk("R6 store if nonzero taken", mem[12'h202], 12'h001);
    chk("R6 never-true store", mem[12'h203], 12'h777);
    chk("R2 pc after skipped stores", pc, 12'h00E);
  endtask

  task automatic t_jump();
    begin_prog();
    ins(0, op(AI, 0, 0, 0, 0), 12'h800);
    ins(2, op(JP, 0, 2, 0, 0), 12'h010);
    ins(4, op(AI, 0, 0, 0, 0), 12'h111);
    ins(6, op(JP, 0, 0, 0, 1), 12'h000);
    ins(12'h10, op(JP, 0, 1, 0, 0), 12'h040);
    ins(12'h12, op(AI, 0, 0, 0, 0), 12'h222);
    ins(12'h14, op(JP, 0, 0, 0, 0), 12'h030);
    ins(12'h16, op(JP, 0, 0, 0, 1), 12'h000);
    ins(12'h30, op(JP, 0, 0, 0, 1), 12'h000);
    ins(12'h40, op(JP, 0, 0, 0, 1), 12'h000);
    run_prog("R7 run");
    chk("R7 jump path acc", acc, 12'h222);
    chk("R7 halt address reached", pc, 12'h032);
  endtask

  task automatic t_io_read();
    begin_prog();
    io_in_data = 12'h3A3;
    ins(0, op(AI, 0, 0, 0, 0), 12'h001);
    ins(2, op(AI, 1, 0, 1, 0), 12'h000);
    ins(4, op(JP, 0, 0, 0, 1), 12'h000);
    run_prog("R8 run");
    chk("R8 input added", acc, 12'h3A4);
    chk("R8 take pulses", in_cnt[11:0], 12'd1);
  endtask

  task automatic t_io_write();
    begin_prog();
    put(12'h300, 12'h0AB);
    ins(0, op(AI, 0, 0, 0, 0), 12'h654);
    ins(2, op(ST, 0, 0, 1, 0), 12'h300);
    ins(4, op(ST, 0, 1, 1, 0), 12'h300);
    ins(6, op(JP, 0, 0, 0, 1), 12'h000);
    run_prog("R9 run");
    chk("R9 output pulses", out_cnt[11:0], 12'd1);
    chk("R9 output word", out_last, 12'h654);
    chk("R9 memory untouched", mem[12'h300], 12'h0AB);
  endtask

  task automatic t_io_test(logic rdy, logic [11:0] exp);
    begin_prog();
    io_ready = rdy;
    ins(0, op(AI, 0, 0, 0, 0), 12'h001);
    ins(2, op(JP, 0, 4, 1, 0), 12'h010);
    ins(4, op(AI, 0, 0, 0, 0), 12'h002);
    ins(6, op(JP, 0, 0, 0, 1), 12'h000);
    ins(12'h10, op(AI, 0, 0, 0, 0), 12'h003);
    ins(12'h12, op(JP, 0, 0, 0, 1), 12'h000);
    run_prog("R6 ready run");
    chk($sformatf("R6 ready=%0d jump", rdy), acc, exp);
  endtask

  task automatic t_selfmod();
    // loop walks a table by rewriting its own operand word at address 7
    begin_prog();
    for (int i = 0; i < 4; i++) put(12'h100 + i, 12'(i + 1));
    ins(0,  op(AI, 0, 0, 0, 0), 12'h000);
    ins(2,  op(ST, 0, 0, 0, 0), 12'h060);
    ins(4,  op(AM, 0, 0, 0, 0), 12'h060);
    ins(6,  op(AM, 1, 0, 0, 0), 12'h100);
    ins(8,  op(ST, 0, 0, 0, 0), 12'h060);
    ins(10, op(AM, 0, 0, 0, 0), 12'h007);
    ins(12, op(AI, 7, 0, 0, 0), 12'h000);
    ins(14, op(ST, 0, 0, 0, 0), 12'h007);
    ins(16, op(AI, 2, 0, 0, 0), 12'h104);
    ins(18, op(JP, 0, 3, 0, 0), 12'h004);
    ins(20, op(JP, 0, 0, 0, 1), 12'h000);
    run_prog("R10 run");
    chk("R10 table sum", mem[12'h060], 12'h00A);
    chk("R10 rewritten operand", mem[12'h007], 12'h104);
    chk("R10 final acc", acc, 12'h000);
    // plant an address then execute it
    begin_prog();
    put(12'h150, 12'hBEE);
    ins(0, op(AI, 0, 0, 0, 0), 12'h150);
    ins(2, op(ST, 0, 0, 0, 0), 12'h005);
    ins(4, op(AM, 0, 0, 0, 0), 12'h000);
    ins(6, op(JP, 0, 0, 0, 1), 12'h000);
    run_prog("R10 plant run");
    chk("R10 planted address load", acc, 12'hBEE);
  endtask

  task automatic t_halt();
    logic [11:0] pc0;
    int busy;
    begin_prog();
    ins(0, op(AI, 0, 0, 0, 0), 12'h0C3);
    ins(2, op(JP, 0, 0, 0, 1), 12'h000);
    ins(4, op(AI, 0, 0, 0, 0), 12'hFFF);
    run_prog("R11 run");
    pc0 = pc;
    busy = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (mem_rd || mem_wr || !halted || pc != pc0) busy++;
    end
    chk("R11 pc at halt", pc0, 12'h004);
    chk("R11 quiet after halt", busy[11:0], 12'd0);
    chk("R12 acc unchanged after halt", acc, 12'h0C3);
  endtask

  initial begin
    io_in_data = '0;
    io_ready = 1'b0;
    t_reset();
    t_alu_imm(12'h9A5, 12'h3C7);
    t_alu_imm(12'hFFF, 12'h001);
    t_alu_mem();
    t_cond_store();
    t_jump();
    t_io_read();
    t_io_write();
    t_io_test(1'b0, 12'h002);
    t_io_test(1'b1, 12'h003);
    t_selfmod();
    t_halt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule